// File: doc/BRIEF.md
# Source-Synchronous Word Burst Transmitter

This block drives the device end of a device-to-host data burst. Sixteen-bit words come from a local word FIFO and go onto a parallel bus together with a toggling strobe. Every transition of the strobe, low-to-high or high-to-low, tells the host that one new word is valid.

The device controller requests a burst with a start pulse. The burst opens only when the host acknowledge is present and the host stop line is low. While the burst runs, the host can hold it by raising its active-low ready line and can close it by raising stop. The device holds the strobe still on its own whenever the FIFO has no word to offer. When the burst closes, the strobe returns to its idle high level, the bus enable falls, and a one-cycle completion pulse is issued. A per-burst word counter is exposed so that checkers can follow the transfer.

Top module: `wordburst_tx`

## Requirements
- R1: Synchronous reset, active high. During reset and after it, the outputs are: strobe high, bus enable low, busy low, done low, pop low, word counter zero.
- R2: When a burst opens, busy and the bus enable are high one cycle after the launching edge, and the strobe is still at its high level.
- R3: Each strobe transition carries exactly one word. The word on the bus at that transition is the next FIFO word in order. Pop is high in the cycle just before that transition. After N word transitions from the high level, the strobe is high if N is even and low if N is odd.
- R4: A word is on the bus for at least one full clock cycle before the strobe transition that marks it, and it stays unchanged through that transition.
- R5: Host ready is active low. While it is high (not ready), no new word is loaded, and at most one strobe transition, already in flight, can still happen.
- R6: While the FIFO valid input is low, the strobe keeps its level and the burst stays open. The burst resumes when words become available again.
- R7: Stop seen in any cycle of an open burst ends the burst. In the next cycle the strobe is high, the bus enable is low, busy is low and done is high for exactly one cycle. No word is popped in the cycle in which stop is seen.
- R8: The word counter is cleared when a burst opens and increases by one at each word transition, modulo 2^CNT_W. After the burst ends, it holds its value until the next burst opens.
- R9: A start pulse is ignored while the acknowledge is low or stop is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst request from the device controller |
| host_ack_i | input | 1 | Host acknowledge, active high |
| host_rdy_n_i | input | 1 | Host ready to receive, active low |
| host_stop_i | input | 1 | Host request to end the burst, active high |
| fifo_vld_i | input | 1 | FIFO head word is valid |
| fifo_dat_i | input | DATA_W | FIFO head word |
| fifo_pop_o | output | 1 | Consume the FIFO head word |
| bus_dat_o | output | DATA_W | Data bus toward the host |
| bus_oe_o | output | 1 | Data bus drive enable |
| strobe_o | output | 1 | Data strobe; each transition marks a word |
| busy_o | output | 1 | A burst is open |
| done_o | output | 1 | One-cycle pulse when a burst ends |
| word_cnt_o | output | CNT_W | Words sent in the current or last burst |

## Verification
The bench builds the block with DATA_W=16 and CNT_W=4, so a single 20-word burst makes the counter wrap.

It sweeps burst lengths from one to six words and follows each with a FIFO starvation gap and a resume. This covers both final strobe parities and the hold-on-empty behaviour. A second sweep places stop at every offset from zero to five cycles after launch, so that stop lands in both the load phase and the transition phase. A long burst with a periodic host-ready pattern shows that at most one transition follows a pause.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

    typedef enum logic [1:0] {
        WBT_IDLE = 2'd0,
        WBT_LOAD = 2'd1,
        WBT_FIRE = 2'd2
    } wbt_state_e;

    typedef struct packed {
        logic launch;   // burst opens this cycle
        logic load;     // head word latched onto the bus
        logic fire;     // strobe transition and pop
        logic abort;    // stop seen during an open burst
    } wbt_ctl_t;

    localparam logic STROBE_IDLE = 1'b1;

    function automatic logic strobe_next(logic cur, wbt_ctl_t c);
        if (c.abort) return STROBE_IDLE;
        if (c.fire)  return ~cur;
        return cur;
    endfunction

endpackage

// File: rtl/wbt_ctrl.sv
module wbt_ctrl
    import wbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     ack_i,
    input  logic     rdy_n_i,
    input  logic     stop_i,
    input  logic     vld_i,
    output wbt_ctl_t ctl_o,
    output logic     busy_o,
    output logic     pop_o
);

    wbt_state_e state_q, state_d;
    logic       arm_q;

    always_comb begin
        ctl_o.launch = (state_q == WBT_IDLE) && start_i && ack_i && !stop_i;
        ctl_o.load   = (state_q == WBT_LOAD) && vld_i && !rdy_n_i && !stop_i;
        ctl_o.fire   = (state_q == WBT_FIRE) && !stop_i;
        ctl_o.abort  = (state_q != WBT_IDLE) && stop_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WBT_IDLE: if (ctl_o.launch) state_d = WBT_LOAD;
            WBT_LOAD: begin
                if (ctl_o.abort)     state_d = WBT_IDLE;
                else if (ctl_o.load) state_d = WBT_FIRE;
            end
            WBT_FIRE: state_d = ctl_o.abort ? WBT_IDLE : WBT_LOAD;
            default:  state_d = WBT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WBT_IDLE;
            arm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            arm_q   <= 1'b1;
        end
    end

    assign busy_o = (state_q != WBT_IDLE);
    assign pop_o  = ctl_o.fire;

    // R5: a transition only follows a cycle in which the host was ready
    p_fire_after_ready_r5: assert property (@(posedge clk) disable iff (rst || !arm_q)
        ctl_o.fire |-> $past(!rdy_n_i));

    // R9: a burst opens only on start with acknowledge and no stop
    p_launch_gated_r9: assert property (@(posedge clk) disable iff (rst || !arm_q)
        $rose(busy_o) |-> $past(start_i && ack_i && !stop_i));

    // R3: a pop never meets an empty FIFO
    p_pop_needs_valid_r3: assert property (@(posedge clk) disable iff (rst || !arm_q)
        pop_o |-> vld_i);

endmodule

// File: rtl/wbt_dpath.sv
module wbt_dpath
    import wbt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  wbt_ctl_t          ctl_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              oe_o,
    output logic              strb_o,
    output logic              done_o
);

    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_o  <= '0;
            oe_o   <= 1'b0;
            strb_o <= STROBE_IDLE;
            done_o <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            arm_q  <= 1'b1;
            if (ctl_i.load) bus_o <= dat_i;
            if (ctl_i.launch)     oe_o <= 1'b1;
            else if (ctl_i.abort) oe_o <= 1'b0;
            strb_o <= strobe_next(strb_o, ctl_i);
            done_o <= ctl_i.abort;
        end
    end

    // R3: any strobe change that is not the end-of-burst return comes from a fire
    p_edge_from_fire_r3: assert property (@(posedge clk) disable iff (rst || !arm_q)
        ((strb_o != $past(strb_o)) && !done_o) |-> $past(ctl_i.fire));

    // R4: the bus does not change across a strobe transition
    p_bus_held_r4: assert property (@(posedge clk) disable iff (rst || !arm_q)
        $past(ctl_i.fire) |-> (bus_o == $past(bus_o)));

    // R7: the burst end leaves the strobe idle and the bus released
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (rst || !arm_q)
        $past(ctl_i.abort) |-> (strb_o && !oe_o && done_o));

    // R7: the completion pulse lasts a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst || !arm_q)
        done_o |=> !done_o);

endmodule

// File: rtl/wbt_wcnt.sv
module wbt_wcnt
    import wbt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wbt_ctl_t         ctl_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            arm_q <= 1'b0;
        end else begin
            arm_q <= 1'b1;
            if (ctl_i.launch)    cnt_o <= '0;
            else if (ctl_i.fire) cnt_o <= cnt_o + ONE;
        end
    end

    // R8: outside a launch the count moves by exactly the number of transitions
    p_count_step_r8: assert property (@(posedge clk) disable iff (rst || !arm_q)
        !$past(ctl_i.launch) |->
            (cnt_o == $past(cnt_o) + {{(CNT_W-1){1'b0}}, $past(ctl_i.fire)}));

endmodule

// File: rtl/wordburst_tx.sv
module wordburst_tx
    import wbt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              host_ack_i,
    input  logic              host_rdy_n_i,
    input  logic              host_stop_i,
    input  logic              fifo_vld_i,
    input  logic [DATA_W-1:0] fifo_dat_i,
    output logic              fifo_pop_o,
    output logic [DATA_W-1:0] bus_dat_o,
    output logic              bus_oe_o,
    output logic              strobe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  word_cnt_o
);

    wbt_ctl_t ctl;

    wbt_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ack_i   (host_ack_i),
        .rdy_n_i (host_rdy_n_i),
        .stop_i  (host_stop_i),
        .vld_i   (fifo_vld_i),
        .ctl_o   (ctl),
        .busy_o  (busy_o),
        .pop_o   (fifo_pop_o)
    );

    wbt_dpath #(.DATA_W(DATA_W)) u_dpath (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .dat_i  (fifo_dat_i),
        .bus_o  (bus_dat_o),
        .oe_o   (bus_oe_o),
        .strb_o (strobe_o),
        .done_o (done_o)
    );

    wbt_wcnt #(.CNT_W(CNT_W)) u_wcnt (
        .clk   (clk),
        .rst   (rst),
        .ctl_i (ctl),
        .cnt_o (word_cnt_o)
    );

endmodule

// File: tb/wordburst_tx_tb_top.sv
module wordburst_tx_tb_top;

    localparam int DW = 16;
    localparam int CW = 4;
    localparam int CMOD = 1 << CW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          start = 1'b0, ack = 1'b0, rdy_n = 1'b0, stop = 1'b0;
    logic          vld, pop, oe, strb, busy, done;
    logic [DW-1:0] dat, bus;
    logic [CW-1:0] cnt;

    int checks = 0;
    int fails  = 0;
    int head   = 0;
    int nfill  = 0;
    int exp_idx = 0;
    int burst_n = 0;
    int pause_edges = 0;
    logic          prev_strb = 1'b1;
    logic [DW-1:0] prev_bus = '0;

    function automatic logic [DW-1:0] word_of(int i);
        return DW'(i * 40503 + 23100) ^ DW'(i << 7);
    endfunction

    assign vld = (head < nfill);
    assign dat = word_of(head);

    always @(posedge clk) begin
        if (rst) head <= 0;
        else if (pop && vld) head <= head + 1;
    end

    wordburst_tx #(.DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .host_ack_i   (ack),
        .host_rdy_n_i (rdy_n),
        .host_stop_i  (stop),
        .fifo_vld_i   (vld),
        .fifo_dat_i   (dat),
        .fifo_pop_o   (pop),
        .bus_dat_o    (bus),
        .bus_oe_o     (oe),
        .strobe_o     (strb),
        .busy_o       (busy),
        .done_o       (done),
        .word_cnt_o   (cnt)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: samples 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if ((strb != prev_strb) && !done) begin
                chk("R3", "word at transition", bus, word_of(exp_idx));
                chk("R4", "bus held before transition", bus, prev_bus);
                chk("R8", "count at transition", cnt, (burst_n + 1) % CMOD);
                exp_idx++;
                burst_n++;
                if (rdy_n) begin
                    pause_edges++;
                    chk("R5", "at most one transition while paused", pause_edges <= 1, 1);
                end
            end
            if (!rdy_n) pause_edges = 0;
            if (done) begin
                chk("R7", "strobe idle high at end", strb, 1);
                chk("R7", "bus released at end", oe, 0);
            end
            prev_strb = strb;
            prev_bus  = bus;
        end
    end

    task automatic start_burst(input int n);
        nfill   = head + n;
        burst_n = 0;
        start   = 1'b1;
        ack     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after launch", busy, 1);
        chk("R2", "enable after launch", oe, 1);
        chk("R2", "strobe high at launch", strb, 1);
    endtask

    task automatic end_burst();
        stop = 1'b1;
        @(negedge clk);
        chk("R7", "done pulse", done, 1);
        chk("R7", "busy cleared", busy, 0);
        chk("R7", "strobe high", strb, 1);
        chk("R7", "no pop without transition", head, exp_idx);
        stop = 1'b0;
        @(negedge clk);
        chk("R7", "done single cycle", done, 0);
        chk("R8", "count held after end", cnt, burst_n % CMOD);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "strobe", strb, 1);
        chk("R1", "enable", oe, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "pop", pop, 0);
        chk("R1", "count", cnt, 0);
        rst = 1'b0;
        @(negedge clk);

        // R9: start without acknowledge, and with stop high
        ack = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "no burst without ack", busy, 0);
        chk("R9", "no enable without ack", oe, 0);
        ack = 1'b1; stop = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk("R9", "no burst with stop", busy, 0);
        @(negedge clk);
        chk("R9", "still idle", busy, 0);

        // Length sweep at full rate, then starvation (R6) and resume
        for (int n = 1; n <= 6; n++) begin
            start_burst(n);
            repeat (2 * n + 3) @(negedge clk);
            chk("R8", "count after full run", cnt, n % CMOD);
            chk("R3", "strobe parity", strb, (n % 2 == 0) ? 1 : 0);
            begin
                logic held;
                held = strb;
                repeat (4) @(negedge clk);
                chk("R6", "strobe holds on empty", strb, held);
                chk("R6", "burst stays open", busy, 1);
            end
            nfill = head + 2;
            repeat (6) @(negedge clk);
            chk("R6", "resume after refill", burst_n, n + 2);
            end_burst();
        end

        // Host pauses over a 20-word burst (counter wraps)
        start_burst(20);
        for (int c = 0; c < 90; c++) begin
            rdy_n = ((c % 7) >= 4) || (c >= 30 && c < 38);
            @(negedge clk);
        end
        rdy_n = 1'b0;
        for (int w = 0; w < 60 && burst_n < 20; w++) @(negedge clk);
        @(negedge clk);
        chk("R5", "all words after pauses", burst_n, 20);
        chk("R8", "wrapped count", cnt, 20 % CMOD);
        end_burst();

        // Stop placed at each offset after launch
        for (int off = 0; off < 6; off++) begin
            start_burst(8);
            repeat (off) @(negedge clk);
            end_burst();
        end

        repeat (2) @(negedge clk);
        chk("R7", "idle after stop sweep", busy, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule